// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash bank as a small synchronous slave. Bus writes are not plain stores: each write cycle is taken as a command byte or as a command argument, and a short sequence of such cycles programs a word, erases a sector, runs a buffered write or switches what a read returns. Reads come back one clock after the request and show either array contents, the status byte, identifier bytes or query-table bytes, depending on the command last accepted.

The bank is `DATA_W/8` byte lanes wide and built from `DATA_W/(8*DEV_BYTES)` parallel devices. A narrow access moves one byte on lane 0; a wide access moves the whole bank at the aligned address, in little- or big-endian lane order selected by an input. A read-only input makes program and erase report failure in the status byte instead of changing the array. No real program or erase time is modelled: every operation completes in the clock of its last write cycle.

Top module: `nor_flash_cmd`

## Requirements
- R1: After reset the block is in read-array mode, the status byte is 0x00 and every array byte reads 0xFF.
- R2: An array read is returned one clock after `rd_en_i`; a wide read at aligned address A gives byte A on lane 0 and A+1 on lane 1 when `big_endian_i` is 0, and the reverse when it is 1; a narrow read gives byte A on lane 0 and zero above; writes use the same lane mapping.
- R3: Command 0x10 or 0x40 followed by one data write stores that data at the write address and sets status bit 7 (0x80).
- R4: Command 0x20 or 0x28 followed by 0xD0 sets every byte of the sector holding the confirm address (address rounded down to `SECTOR_BYTES`) to 0xFF, leaves other sectors unchanged and sets status bit 7.
- R5: Command 0x20 or 0x28 followed by 0xFF returns to read-array mode without erasing.
- R6: With `read_only_i` high the array is left unchanged; a program sets status bits 4 and 7 (0x90) and an erase sets bits 5 and 7 (0xA0).
- R7: Command 0x50 clears the status byte to 0x00 and returns to read-array mode.
- R8: While the active command is 0x10, 0x20, 0x28, 0x40, 0x60, 0x70 or 0xE8, reads return the status byte in the low byte of every device's lane group for a wide read, and in lane 0 only for a narrow read.
- R9: Command 0x60 followed by 0x01 or 0xD0 stays in status-read mode without touching the array; any other second byte returns to read-array mode.
- R10: Command 0x90 selects identifier reads: with byte offset B = address shifted right by log2 of the lane count, B=0 returns `MFR_ID`, B=1 returns `DEV_ID`, any other B returns 0, replicated per device like status.
- R11: Command 0x98 selects query reads at offset B: 0x10/0x11/0x12 give 0x51/0x52/0x59, 0x13 gives 0x01, 0x27 gives log2 of bytes per device, 0x2A gives log2 of the write buffer (8 for a one-lane bank, 11 otherwise), 0x2C gives 0x01, 0x2D gives sector count minus one, all others 0.
- R12: Command 0xE8 sets status bit 7, takes a count N from the low `DEV_BYTES*8` bits of the next write, stores the next N+1 data writes, then needs 0xD0 to finish in status mode; any other byte in that confirm cycle returns to read-array mode and is not stored.
- R13: An unrecognised command, an invalid second byte, or 0xFF in any cycle that does not carry data returns to read-array mode at the end of that same write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data; command byte in bits 7:0 |
| wr_en_i | input | 1 | Write cycle strobe |
| rd_en_i | input | 1 | Read request strobe |
| wide_i | input | 1 | 1: full-bank access, 0: single byte on lane 0 |
| big_endian_i | input | 1 | Lane order for wide array accesses |
| read_only_i | input | 1 | Array is write-protected |
| rd_data_o | output | DATA_W | Read data, valid one clock after rd_en_i |

## Verification
A wrong cycle counter or a stale command register shows on the very next read as the wrong source: status where array data belongs, or array data where status is expected, so every sequence is followed by a read. A wrong count in a buffered write shows as a confirm byte stored as data or a dropped data word, visible one read later at the affected address. A wrong status bit shows in both lanes of the first wide read after the operation, and an erase over the wrong range shows at a neighbouring sector's byte.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

  typedef enum logic [1:0] {CYC_IDLE, CYC_ARG, CYC_DATA, CYC_CONF} cyc_e;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID, RD_QUERY} rd_sel_e;

  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE_A = 8'h20;
  localparam logic [7:0] OP_ERASE_B = 8'h28;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUF     = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_LOCKSET = 8'h01;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_NONE    = 8'h00;

  localparam int ST_READY = 7;
  localparam int ST_ERSF  = 5;
  localparam int ST_PRGF  = 4;

  function automatic rd_sel_e rd_sel_of(logic [7:0] c);
    case (c)
      OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B,
      OP_CLR, OP_LOCK, OP_STAT, OP_BUF: rd_sel_of = RD_STATUS;
      OP_IDENT:                         rd_sel_of = RD_ID;
      OP_QUERY:                         rd_sel_of = RD_QUERY;
      default:                          rd_sel_of = RD_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nfl_cmd_fsm.sv
module nfl_cmd_fsm
  import nfl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] arg_i,
  input  logic             read_only_i,
  output logic             arr_wr_o,
  output logic             arr_erase_o,
  output logic [7:0]       cmd_o,
  output logic [7:0]       status_o
);

  cyc_e             cyc_q, cyc_n;
  logic [7:0]       cmd_q, cmd_n, st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       op;

  assign op = arg_i[7:0];

  always_comb begin
    cyc_n = cyc_q;
    cmd_n = cmd_q;
    st_n  = st_q;
    cnt_n = cnt_q;
    arr_wr_o    = 1'b0;
    arr_erase_o = 1'b0;
    if (wr_en_i) begin
      unique case (cyc_q)
        CYC_IDLE: begin
          unique case (op)
            OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_LOCK: begin
              cmd_n = op;
              cyc_n = CYC_ARG;
            end
            OP_BUF: begin
              cmd_n = op;
              cyc_n = CYC_ARG;
              st_n[ST_READY] = 1'b1;
            end
            OP_STAT, OP_IDENT, OP_QUERY: cmd_n = op;
            OP_CLR: begin
              st_n  = 8'h00;
              cmd_n = OP_NONE;
            end
            default: cmd_n = OP_NONE;
          endcase
        end
        CYC_ARG: begin
          cyc_n = CYC_IDLE;
          unique case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              arr_wr_o = !read_only_i;
              if (read_only_i) st_n[ST_PRGF] = 1'b1;
              st_n[ST_READY] = 1'b1;
            end
            OP_ERASE_A, OP_ERASE_B: begin
              if (op == OP_CONFIRM) begin
                arr_erase_o = !read_only_i;
                if (read_only_i) st_n[ST_ERSF] = 1'b1;
                st_n[ST_READY] = 1'b1;
              end else begin
                cmd_n = OP_NONE;
              end
            end
            OP_LOCK: begin
              if (op != OP_LOCKSET && op != OP_CONFIRM) cmd_n = OP_NONE;
            end
            OP_BUF: begin
              cnt_n = arg_i;
              cyc_n = CYC_DATA;
            end
            default: cmd_n = OP_NONE;
          endcase
        end
        CYC_DATA: begin
          arr_wr_o = !read_only_i;
          if (read_only_i) st_n[ST_PRGF] = 1'b1;
          if (cnt_q == '0) cyc_n = CYC_CONF;
          else             cnt_n = cnt_q - 1'b1;
        end
        CYC_CONF: begin
          cyc_n = CYC_IDLE;
          if (op == OP_CONFIRM) st_n[ST_READY] = 1'b1;
          else                  cmd_n = OP_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= CYC_IDLE;
      cmd_q <= OP_NONE;
      st_q  <= 8'h00;
      cnt_q <= '0;
    end else begin
      cyc_q <= cyc_n;
      cmd_q <= cmd_n;
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign cmd_o    = cmd_q;
  assign status_o = st_q;

  // R12
  buf_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_DATA || cyc_q == CYC_CONF) |-> cmd_q == OP_BUF);

  // R4
  erase_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_erase_o |=> st_q[ST_READY]);

  // R13
  ff_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cyc_q == CYC_IDLE && op == OP_ARRAY) |=> (cmd_q == OP_NONE && cyc_q == CYC_IDLE));

  // R7
  clr_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cyc_q == CYC_IDLE && op == OP_CLR) |=> (st_q == 8'h00 && cmd_q == OP_NONE));

endmodule

// File: rtl/nfl_array.sv
module nfl_array #(
  parameter int LANES        = 2,
  parameter int MEM_BYTES    = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int ADDR_W       = $clog2(MEM_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LANES*8-1:0]  wdata_i,
  input  logic                wide_i,
  input  logic                be_i,
  input  logic                wr_i,
  input  logic                erase_i,
  output logic [LANES*8-1:0]  rdata_o
);

  localparam int SEC_W  = $clog2(SECTOR_BYTES);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [7:0]        mem_q [MEM_BYTES];
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] lane_idx [LANES];
  logic [LANES-1:0]  lane_act;

  assign base = (LANES > 1) ? ((addr_i >> LANE_W) << LANE_W) : addr_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_act[l] = wide_i || (l == 0);
    assign lane_idx[l] = wide_i ? (base | ADDR_W'(be_i ? (LANES - 1 - l) : l)) : addr_i;
    assign rdata_o[l*8 +: 8] = lane_act[l] ? mem_q[lane_idx[l]] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else begin
      if (erase_i) begin
        for (int i = 0; i < MEM_BYTES; i++)
          if ((ADDR_W'(i) >> SEC_W) == (addr_i >> SEC_W)) mem_q[i] <= 8'hFF;
      end
      if (wr_i) begin
        for (int l = 0; l < LANES; l++)
          if (lane_act[l]) mem_q[lane_idx[l]] <= wdata_i[l*8 +: 8];
      end
    end
  end

  // R4
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && !wr_i) |=> mem_q[$past(addr_i)] == 8'hFF);

endmodule

// File: rtl/nfl_rd_mux.sv
module nfl_rd_mux
  import nfl_pkg::*;
#(
  parameter int   LANES        = 2,
  parameter int   DEV_BYTES    = 1,
  parameter int   MEM_BYTES    = 256,
  parameter int   SECTOR_BYTES = 64,
  parameter logic [7:0] MFR_ID = 8'h89,
  parameter logic [7:0] DEV_ID = 8'h18,
  parameter int   ADDR_W       = $clog2(MEM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic               wide_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         cmd_i,
  input  logic [7:0]         status_i,
  input  logic [LANES*8-1:0] arr_rdata_i,
  output logic [LANES*8-1:0] rd_data_o
);

  localparam int LANE_SH  = $clog2(LANES);
  localparam int NDEV     = LANES / DEV_BYTES;
  localparam int DEV_LOG2 = $clog2(MEM_BYTES / NDEV);
  localparam int BUF_LOG2 = (LANES == 1) ? 8 : 11;
  localparam int NSEC     = MEM_BYTES / SECTOR_BYTES;

  rd_sel_e          sel;
  logic [7:0]       boff, id_byte, qry_byte, dev_byte;
  logic [LANES*8-1:0] rd_n, rd_q;

  assign sel  = rd_sel_of(cmd_i);
  assign boff = 8'(addr_i >> LANE_SH);

  always_comb begin
    unique case (boff)
      8'h00:   id_byte = MFR_ID;
      8'h01:   id_byte = DEV_ID;
      default: id_byte = 8'h00;
    endcase
    unique case (boff)
      8'h10:   qry_byte = 8'h51;
      8'h11:   qry_byte = 8'h52;
      8'h12:   qry_byte = 8'h59;
      8'h13:   qry_byte = 8'h01;
      8'h27:   qry_byte = 8'(DEV_LOG2);
      8'h2A:   qry_byte = 8'(BUF_LOG2);
      8'h2C:   qry_byte = 8'h01;
      8'h2D:   qry_byte = 8'(NSEC - 1);
      default: qry_byte = 8'h00;
    endcase
    unique case (sel)
      RD_STATUS: dev_byte = status_i;
      RD_ID:     dev_byte = id_byte;
      default:   dev_byte = qry_byte;
    endcase
    rd_n = arr_rdata_i;
    if (sel != RD_ARRAY) begin
      rd_n = '0;
      for (int l = 0; l < LANES; l++)
        if ((wide_i || l == 0) && (l % DEV_BYTES) == 0) rd_n[l*8 +: 8] = dev_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_n;
  end

  assign rd_data_o = rd_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R8
  stat_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == RD_STATUS) |=> rd_data_o[7:0] == $past(status_i));

  // R2
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wide_i && LANES > 1) |=> rd_data_o[LANES*8-1:8] == '0);

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd #(
  parameter int   DATA_W       = 16,
  parameter int   DEV_BYTES    = 1,
  parameter int   MEM_BYTES    = 256,
  parameter int   SECTOR_BYTES = 64,
  parameter logic [7:0] MFR_ID = 8'h89,
  parameter logic [7:0] DEV_ID = 8'h18,
  parameter int   ADDR_W       = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              wide_i,
  input  logic              big_endian_i,
  input  logic              read_only_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = DEV_BYTES * 8;

  logic              arr_wr, arr_erase;
  logic [7:0]        cmd, status;
  logic [DATA_W-1:0] arr_rdata;

  nfl_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .arg_i       (wdata_i[CNT_W-1:0]),
    .read_only_i (read_only_i),
    .arr_wr_o    (arr_wr),
    .arr_erase_o (arr_erase),
    .cmd_o       (cmd),
    .status_o    (status)
  );

  nfl_array #(
    .LANES(LANES), .MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wide_i  (wide_i),
    .be_i    (big_endian_i),
    .wr_i    (arr_wr),
    .erase_i (arr_erase),
    .rdata_o (arr_rdata)
  );

  nfl_rd_mux #(
    .LANES(LANES), .DEV_BYTES(DEV_BYTES), .MEM_BYTES(MEM_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .wide_i      (wide_i),
    .addr_i      (addr_i),
    .cmd_i       (cmd),
    .status_i    (status),
    .arr_rdata_i (arr_rdata),
    .rd_data_o   (rd_data_o)
  );

  // R6
  ro_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_only_i |-> !(arr_wr || arr_erase));

endmodule

// File: tb/nor_flash_cmd_tb_top.sv
`timescale 1ns/1ps
module nor_flash_cmd_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wide = 1'b1, be = 1'b0, ro = 1'b0;
  logic [15:0] rd_data;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0]  ref_mem [256];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  nor_flash_cmd dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wide_i(wide),
    .big_endian_i(be), .read_only_i(ro), .rd_data_o(rd_data)
  );

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic w = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; wide = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a; wide = w; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // behavioural array model, lane order as in R2
  task automatic mdl_store(input logic [7:0] a, input logic [15:0] d, input logic w);
    logic [7:0] b;
    if (!w) ref_mem[a] = d[7:0];
    else begin
      b = {a[7:1], 1'b0};
      if (be) begin ref_mem[b] = d[15:8]; ref_mem[b+1] = d[7:0]; end
      else    begin ref_mem[b] = d[7:0];  ref_mem[b+1] = d[15:8]; end
    end
  endtask

  function automatic logic [15:0] mdl_rd(input logic [7:0] a, input logic w);
    logic [7:0] b;
    b = {a[7:1], 1'b0};
    if (!w) return {8'h00, ref_mem[a]};
    return be ? {ref_mem[b], ref_mem[b+1]} : {ref_mem[b+1], ref_mem[b]};
  endfunction

  task automatic prog(input logic [7:0] a, input logic [15:0] d);
    wr(a, 16'h0040);
    wr(a, d);
    if (!ro) mdl_store(a, d, 1'b1);
  endtask

  // monitor: pops expected items as read data appears
  initial forever begin
    @(posedge clk); #1;
    if (rd_en) begin
      @(negedge clk);
      n_vec++;
      if (rd_data !== exp_q[0]) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", tag_q[0], rd_data, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 1, 16'hFFFF, "R1 erased array");
    rd(8'hFE, 1, 16'hFFFF, "R1 erased array top");
    wr(8'h00, 16'h0070);
    rd(8'h00, 1, 16'h0000, "R1 status zero");
    wr(8'h00, 16'h00FF);

    // R3 program, R8 status lanes, R2 read order
    prog(8'h10, 16'hA55A);
    rd(8'h10, 1, 16'h8080, "R3 R8 status after program wide");
    rd(8'h10, 0, 16'h0080, "R8 status narrow");
    wr(8'h00, 16'h00FF);
    rd(8'h10, 1, mdl_rd(8'h10, 1), "R3 programmed word");
    rd(8'h11, 0, mdl_rd(8'h11, 0), "R2 narrow byte");
    be = 1'b1;
    rd(8'h10, 1, 16'h5AA5, "R2 big-endian read");
    prog(8'h20, 16'h1234);
    wr(8'h00, 16'h00FF);
    be = 1'b0;
    rd(8'h20, 1, 16'h3412, "R2 big-endian write");

    // R7 clear status
    wr(8'h00, 16'h0050);
    rd(8'h10, 1, mdl_rd(8'h10, 1), "R7 back to array");
    wr(8'h00, 16'h0070);
    rd(8'h00, 1, 16'h0000, "R7 status cleared");

    // R4 erase with confirm
    prog(8'h44, 16'h7777);
    wr(8'h40, 16'h0020);
    wr(8'h47, 16'h00D0);
    for (int i = 8'h40; i < 8'h80; i++) ref_mem[i] = 8'hFF;
    rd(8'h44, 1, 16'h8080, "R4 ready after erase");
    wr(8'h00, 16'h00FF);
    rd(8'h44, 1, 16'hFFFF, "R4 sector erased");
    rd(8'h10, 1, 16'hA55A, "R4 other sector kept");

    // R5 abort
    prog(8'h80, 16'h00C3);
    wr(8'h00, 16'h00FF);
    wr(8'h80, 16'h0028);
    wr(8'h80, 16'h00FF);
    rd(8'h80, 1, 16'h00C3, "R5 abort keeps data");

    // R6 read-only
    wr(8'h00, 16'h0050);
    ro = 1'b1;
    prog(8'h80, 16'h9999);
    rd(8'h80, 1, 16'h9090, "R6 program fail status");
    wr(8'h00, 16'h00FF);
    rd(8'h80, 1, 16'h00C3, "R6 array unchanged by program");
    wr(8'h00, 16'h0050);
    wr(8'h80, 16'h0020);
    wr(8'h80, 16'h00D0);
    rd(8'h80, 1, 16'hA0A0, "R6 erase fail status");
    wr(8'h00, 16'h00FF);
    rd(8'h80, 1, 16'h00C3, "R6 array unchanged by erase");
    ro = 1'b0;
    wr(8'h00, 16'h0050);

    // R9 lock
    wr(8'h80, 16'h0060);
    wr(8'h80, 16'h0001);
    rd(8'h80, 1, 16'h0000, "R9 lock stays in status");
    wr(8'h00, 16'h00FF);
    wr(8'h80, 16'h0060);
    wr(8'h80, 16'h0033);
    rd(8'h80, 1, 16'h00C3, "R9 R13 bad lock byte");

    // R13 unknown command, bad erase second byte
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h0077);
    rd(8'h80, 1, 16'h00C3, "R13 unknown command");
    wr(8'h80, 16'h0020);
    wr(8'h80, 16'h0055);
    rd(8'h80, 1, 16'h00C3, "R13 bad erase confirm");

    // R10 identifier
    wr(8'h00, 16'h0090);
    rd(8'h00, 1, 16'h8989, "R10 manufacturer");
    rd(8'h02, 1, 16'h1818, "R10 device");
    rd(8'h02, 0, 16'h0018, "R10 narrow");
    rd(8'h04, 1, 16'h0000, "R10 other offset");
    wr(8'h00, 16'h00FF);

    // R11 query
    wr(8'h00, 16'h0098);
    rd(8'h20, 1, 16'h5151, "R11 Q");
    rd(8'h22, 1, 16'h5252, "R11 R");
    rd(8'h24, 0, 16'h0059, "R11 Y narrow");
    rd(8'h54, 1, 16'h0B0B, "R11 buffer size");
    rd(8'h4E, 1, 16'h0707, "R11 device size");
    rd(8'h5A, 1, 16'h0303, "R11 sector count");
    rd(8'hC0, 1, 16'h0000, "R11 out of table");
    wr(8'h00, 16'h00FF);

    // R12 buffered write
    wr(8'h00, 16'h0050);
    wr(8'hC0, 16'h00E8);
    wr(8'hC0, 16'h0002);
    wr(8'hC0, 16'h1111);
    wr(8'hC2, 16'h2222);
    wr(8'hC4, 16'h3333);
    rd(8'hC0, 1, 16'h8080, "R12 status while waiting confirm");
    wr(8'hC0, 16'h00D0);
    rd(8'hC0, 1, 16'h8080, "R12 status after confirm");
    wr(8'h00, 16'h00FF);
    rd(8'hC0, 1, 16'h1111, "R12 word 0");
    rd(8'hC2, 1, 16'h2222, "R12 word 1");
    rd(8'hC4, 1, 16'h3333, "R12 word 2");
    wr(8'hE0, 16'h00E8);
    wr(8'hE0, 16'h0301);
    wr(8'hE0, 16'h0101);
    wr(8'hE2, 16'h0202);
    wr(8'hE4, 16'h00D0);
    wr(8'h00, 16'h00FF);
    rd(8'hE4, 1, 16'hFFFF, "R12 count masked, confirm not stored");
    rd(8'hE2, 1, 16'h0202, "R12 masked count last word");
    wr(8'hD0, 16'h00E8);
    wr(8'hD0, 16'h0000);
    wr(8'hD0, 16'hBEEF);
    wr(8'hD2, 16'hAAAA);
    rd(8'hD2, 1, 16'hFFFF, "R12 underflow write dropped");
    rd(8'hD0, 1, 16'hBEEF, "R12 single word stored");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule